// File: doc/BRIEF.md
# DMA Transfer Submission Queue

This block is the register-side front end of a single-channel DMA engine. Software reaches it through a 32-bit register bus. It fills a set of staging registers with the fields of one transfer, then writes a commit command. Each commit is handed to a short descriptor queue together with a small ID that the block chose. Software can read that ID before it commits. A data mover on the far side takes descriptors from the head of the queue and later reports each one as finished. A finish may be early, in which case it comes with the number of bytes actually moved.

Completion is not a single flag. Finished transfers show up as one bit per ID in a done word. Early finishes of transfers that asked for it are also stored as length/ID records, and software pops these records by reading two registers. Two interrupt causes are latched: a commit was accepted, and a transfer finished. Each cause can be masked. A control register turns the channel on, holds the queue head back (pause), or wipes every queued and outstanding transfer.

Top module: `dma_submit_ctl`

## Requirements
- R1: After reset the mask register (0x80) reads 3 and all other registers read 0. This includes pending (0x84), control (0x400), next ID (0x404), commit (0x408), done word (0x428) and status (0x430). The irq output is 0.
- R2: Writing 1 in bit 0 of 0x408 while control bit 0 is set enqueues the staged fields with the ID that 0x404 showed. The staged fields are destination 0x410, source 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424 and flags 0x40C. The next ID then steps by one, modulo QDEPTH.
- R3: At most QDEPTH transfers can be outstanding, counted from acceptance to completion. A commit made while the limit is reached stays waiting, and 0x408 reads 1 until a completion frees a slot. The commit is then accepted without another write.
- R4: The queue head is offered in commit order. hd_valid is 0 while control bit 1 (pause) is set, and the head is offered again once pause is cleared.
- R5: A completion for ID n sets bit n of the done word. Bit n clears when ID n is handed out again.
- R6: Pending bit 0 is set when a commit is accepted. Pending bit 1 is set when a completion is taken. Writing 1s to 0x84 clears those bits. An event in the same cycle as its clear leaves the bit set.
- R7: Register 0x88 reads pending AND NOT mask. irq is the OR of those bits, and a mask bit of 1 suppresses its cause.
- R8: A completion with cmp_partial for a transfer committed with flags bit 2 stores a length/ID record. Bit 31 of the done word is 1 while a record is stored. Reading 0x44C gives the record's length, and reading 0x450 gives its ID and removes the record. A transfer committed without flags bit 2 stores no record.
- R9: Writing control with bit 0 at 0 discards all queued and outstanding transfers and any waiting commit. While disabled, commits and completions have no effect.
- R10: Status bit 0 reads 1 while a commit waits or any transfer is outstanding.
- R11: The X length register keeps LEN_W bits, so writing all ones reads back 2^LEN_W-1. The flags register keeps 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| hd_valid | output | 1 | Queue head offered to the mover |
| hd_take | input | 1 | Mover takes the head |
| hd_id | output | IDW | ID of the head transfer |
| hd_src | output | AW | Head source address |
| hd_dst | output | AW | Head destination address |
| hd_xlen | output | LEN_W | Head X length field |
| hd_ylen | output | YW | Head Y length field |
| hd_src_stride | output | AW | Head source stride |
| hd_dst_stride | output | AW | Head destination stride |
| hd_flags | output | 3 | Head flags (cyclic, last, partial report) |
| cmp_valid | input | 1 | Mover reports a finished transfer |
| cmp_id | input | IDW | ID of the finished transfer |
| cmp_partial | input | 1 | Transfer ended early |
| cmp_len | input | LEN_W | Bytes moved for an early end |

## Verification
Two pairs of events can land in the same cycle. A commit can be accepted on the same edge that a completion for an older ID is taken. In that case the outstanding count must stay level, the old ID's done bit must rise and the new ID's bit must clear. A software clear of a pending bit can also meet a fresh event of that cause. The bench provokes both by driving the bus write and cmp_valid in the same cycle. It then judges the result from the commit register, the next-ID register, the done word and the pending register, all against its own bitmap model.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam logic [11:0] OFF_MASK    = 12'h080;
  localparam logic [11:0] OFF_PEND    = 12'h084;
  localparam logic [11:0] OFF_SRCIRQ  = 12'h088;
  localparam logic [11:0] OFF_CTRL    = 12'h400;
  localparam logic [11:0] OFF_NEXTID  = 12'h404;
  localparam logic [11:0] OFF_COMMIT  = 12'h408;
  localparam logic [11:0] OFF_FLAGS   = 12'h40C;
  localparam logic [11:0] OFF_DST     = 12'h410;
  localparam logic [11:0] OFF_SRC     = 12'h414;
  localparam logic [11:0] OFF_XLEN    = 12'h418;
  localparam logic [11:0] OFF_YLEN    = 12'h41C;
  localparam logic [11:0] OFF_DSTR    = 12'h420;
  localparam logic [11:0] OFF_SSTR    = 12'h424;
  localparam logic [11:0] OFF_DONE    = 12'h428;
  localparam logic [11:0] OFF_ACTID   = 12'h42C;
  localparam logic [11:0] OFF_STATUS  = 12'h430;
  localparam logic [11:0] OFF_PLEN    = 12'h44C;
  localparam logic [11:0] OFF_PID     = 12'h450;

  localparam int FLAG_CYCLIC = 0;
  localparam int FLAG_LAST   = 1;
  localparam int FLAG_REPORT = 2;

  localparam int IRQ_SOT = 0;
  localparam int IRQ_EOT = 1;
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push && !full) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop && !empty) rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end

  assign dout  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush) |-> !empty);
  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/dsq_id_track.sv
module dsq_id_track #(
  parameter int QDEPTH = 4,
  localparam int IDW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  logic              alloc_rpt,
  input  logic              cmp_en,
  input  logic [IDW-1:0]    cmp_id,
  output logic [IDW-1:0]    next_id,
  output logic [QDEPTH-1:0] done,
  output logic              cmp_rpt,
  output logic [CW-1:0]     outstanding,
  output logic              can_alloc
);
  localparam logic [IDW-1:0] LAST_ID = IDW'(QDEPTH - 1);
  logic [QDEPTH-1:0] rpt;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_id     <= '0;
      done        <= '0;
      rpt         <= '0;
      outstanding <= '0;
    end else begin
      if (alloc) begin
        next_id       <= (next_id == LAST_ID) ? '0 : next_id + 1'b1;
        done[next_id] <= 1'b0;
        rpt[next_id]  <= alloc_rpt;
      end
      if (cmp_en) done[cmp_id] <= 1'b1;
      if (flush) outstanding <= '0;
      else       outstanding <= outstanding + CW'(alloc) - CW'(cmp_en);
    end
  end

  assign cmp_rpt   = rpt[cmp_id];
  assign can_alloc = (outstanding < CW'(QDEPTH));

  // R3
  out_bound_chk: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CW'(QDEPTH));
  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_en |=> done[$past(cmp_id)]);
  // R5
  realloc_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc && !(cmp_en && cmp_id == next_id)) |=> !done[$past(next_id)]);
  // R2
  id_step_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |=> (next_id != $past(next_id)));
endmodule

// File: rtl/dsq_irq_ctl.sv
module dsq_irq_ctl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic [NSRC-1:0] pend_n, mask_n;

  always_comb begin
    pend_n = (pend & ~(clr_we ? clr_bits : '0)) | set;
    mask_n = mask_we ? mask_bits : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '1;
      irq  <= 1'b0;
    end else begin
      pend <= pend_n;
      mask <= mask_n;
      irq  <= |(pend_n & ~mask_n);
    end
  end

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((pend & $past(set)) == $past(set)));
  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend & ~mask));
endmodule

// File: rtl/dma_submit_ctl.sv
module dma_submit_ctl #(
  parameter int QDEPTH = 4,
  parameter int PDEPTH = 4,
  parameter int AW     = 32,
  parameter int LEN_W  = 24,
  parameter int YW     = 16,
  localparam int IDW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             hd_valid,
  input  logic             hd_take,
  output logic [IDW-1:0]   hd_id,
  output logic [AW-1:0]    hd_src,
  output logic [AW-1:0]    hd_dst,
  output logic [LEN_W-1:0] hd_xlen,
  output logic [YW-1:0]    hd_ylen,
  output logic [AW-1:0]    hd_src_stride,
  output logic [AW-1:0]    hd_dst_stride,
  output logic [2:0]       hd_flags,
  input  logic             cmp_valid,
  input  logic [IDW-1:0]   cmp_id,
  input  logic             cmp_partial,
  input  logic [LEN_W-1:0] cmp_len
);
  import dsq_pkg::*;

  localparam int DW = IDW + 4 * AW + LEN_W + YW + 3;
  localparam int RW = IDW + LEN_W;
  localparam int CW = $clog2(QDEPTH + 1);

  // control and staging registers
  logic             en, pause, start_pend;
  logic [2:0]       stg_flags;
  logic [AW-1:0]    stg_dst, stg_src, stg_dstr, stg_sstr;
  logic [LEN_W-1:0] stg_xlen;
  logic [YW-1:0]    stg_ylen;
  logic [IDW-1:0]   act_id;

  // cross-module nets
  logic [IDW-1:0]    next_id;
  logic [QDEPTH-1:0] done_bits;
  logic              cmp_rpt, can_alloc;
  logic [CW-1:0]     outstanding;
  logic              q_empty, q_full, q_pop;
  logic [DW-1:0]     q_din, q_dout;
  logic              p_empty, p_full, p_push, p_pop;
  logic [RW-1:0]     p_dout;
  logic [1:0]        irq_pend, irq_mask;

  logic ctrl_wr, flush, start_wr, want, accept, cmp_en;

  always_comb begin
    ctrl_wr  = bus_wr && (bus_addr == OFF_CTRL);
    flush    = ctrl_wr && !bus_wdata[0];
    start_wr = bus_wr && (bus_addr == OFF_COMMIT) && bus_wdata[0];
    want     = en && !flush && (start_wr || start_pend);
    accept   = want && can_alloc && !q_full;
    cmp_en   = cmp_valid && en && !flush && (outstanding != '0);
    q_pop    = hd_take && hd_valid;
    p_push   = cmp_en && cmp_partial && cmp_rpt && !p_full;
    p_pop    = bus_rd && (bus_addr == OFF_PID) && !p_empty;
    q_din    = {next_id, stg_src, stg_dst, stg_sstr, stg_dstr,
                stg_xlen, stg_ylen, stg_flags};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      pause      <= 1'b0;
      start_pend <= 1'b0;
      stg_flags  <= '0;
      stg_dst    <= '0;
      stg_src    <= '0;
      stg_dstr   <= '0;
      stg_sstr   <= '0;
      stg_xlen   <= '0;
      stg_ylen   <= '0;
      act_id     <= '0;
    end else begin
      if (ctrl_wr) {pause, en} <= bus_wdata[1:0];
      if (bus_wr) begin
        unique case (bus_addr)
          OFF_FLAGS: stg_flags <= bus_wdata[2:0];
          OFF_DST:   stg_dst   <= bus_wdata[AW-1:0];
          OFF_SRC:   stg_src   <= bus_wdata[AW-1:0];
          OFF_XLEN:  stg_xlen  <= bus_wdata[LEN_W-1:0];
          OFF_YLEN:  stg_ylen  <= bus_wdata[YW-1:0];
          OFF_DSTR:  stg_dstr  <= bus_wdata[AW-1:0];
          OFF_SSTR:  stg_sstr  <= bus_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (flush || accept) start_pend <= 1'b0;
      else if (want)       start_pend <= 1'b1;
      if (q_pop) act_id <= hd_id;
    end
  end

  dsq_id_track #(.QDEPTH(QDEPTH)) ids_i (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc(accept), .alloc_rpt(stg_flags[FLAG_REPORT]),
    .cmp_en(cmp_en), .cmp_id(cmp_id),
    .next_id(next_id), .done(done_bits), .cmp_rpt(cmp_rpt),
    .outstanding(outstanding), .can_alloc(can_alloc)
  );

  dsq_fifo #(.DEPTH(QDEPTH), .W(DW)) queue_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(accept), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  dsq_fifo #(.DEPTH(PDEPTH), .W(RW)) partial_i (
    .clk(clk), .rst(rst), .flush(1'b0),
    .push(p_push), .din({cmp_id, cmp_len}), .pop(p_pop),
    .dout(p_dout), .empty(p_empty), .full(p_full)
  );

  dsq_irq_ctl #(.NSRC(2)) irq_i (
    .clk(clk), .rst(rst),
    .set({cmp_en, accept}),
    .clr_we(bus_wr && (bus_addr == OFF_PEND)), .clr_bits(bus_wdata[1:0]),
    .mask_we(bus_wr && (bus_addr == OFF_MASK)), .mask_bits(bus_wdata[1:0]),
    .pend(irq_pend), .mask(irq_mask), .irq(irq)
  );

  assign hd_valid = !q_empty && en && !pause;
  assign {hd_id, hd_src, hd_dst, hd_src_stride, hd_dst_stride,
          hd_xlen, hd_ylen, hd_flags} = q_dout;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      OFF_MASK:   rd_val[1:0] = irq_mask;
      OFF_PEND:   rd_val[1:0] = irq_pend;
      OFF_SRCIRQ: rd_val[1:0] = irq_pend & ~irq_mask;
      OFF_CTRL:   rd_val[1:0] = {pause, en};
      OFF_NEXTID: rd_val[IDW-1:0] = next_id;
      OFF_COMMIT: rd_val[0] = start_pend;
      OFF_FLAGS:  rd_val[2:0] = stg_flags;
      OFF_DST:    rd_val[AW-1:0] = stg_dst;
      OFF_SRC:    rd_val[AW-1:0] = stg_src;
      OFF_XLEN:   rd_val[LEN_W-1:0] = stg_xlen;
      OFF_YLEN:   rd_val[YW-1:0] = stg_ylen;
      OFF_DSTR:   rd_val[AW-1:0] = stg_dstr;
      OFF_SSTR:   rd_val[AW-1:0] = stg_sstr;
      OFF_DONE: begin
        rd_val[QDEPTH-1:0] = done_bits;
        rd_val[31]         = !p_empty;
      end
      OFF_ACTID:  rd_val[IDW-1:0] = act_id;
      OFF_STATUS: rd_val[0] = start_pend || (outstanding != '0);
      OFF_PLEN:   rd_val[LEN_W-1:0] = p_empty ? '0 : p_dout[LEN_W-1:0];
      OFF_PID:    rd_val[IDW-1:0] = p_empty ? '0 : p_dout[RW-1:LEN_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!hd_valid && !start_pend));
  // R3
  wait_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (want && !can_alloc) |=> start_pend);
endmodule

// File: tb/dma_submit_ctl_tb.sv
module dma_submit_ctl_tb_top;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, hd_valid, hd_take = 0;
  logic [1:0]  hd_id;
  logic [31:0] hd_src, hd_dst, hd_src_stride, hd_dst_stride;
  logic [23:0] hd_xlen;
  logic [15:0] hd_ylen;
  logic [2:0]  hd_flags;
  logic        cmp_valid = 0, cmp_partial = 0;
  logic [1:0]  cmp_id = '0;
  logic [23:0] cmp_len = '0;

  int n_chk = 0, n_err = 0;
  logic [3:0]  done_m = '0;
  logic [1:0]  mid = '0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dma_submit_ctl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .hd_valid(hd_valid), .hd_take(hd_take), .hd_id(hd_id),
    .hd_src(hd_src), .hd_dst(hd_dst), .hd_xlen(hd_xlen), .hd_ylen(hd_ylen),
    .hd_src_stride(hd_src_stride), .hd_dst_stride(hd_dst_stride),
    .hd_flags(hd_flags), .cmp_valid(cmp_valid), .cmp_id(cmp_id),
    .cmp_partial(cmp_partial), .cmp_len(cmp_len)
  );

  function automatic logic [1:0] id_after(logic [1:0] id);
    return 2'((int'(id) + 1) % QD);
  endfunction

  function automatic logic [31:0] done_word(logic [3:0] bits, logic prec);
    return {prec, 27'd0, bits};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic take();
    @(negedge clk); hd_take = 1;
    @(negedge clk); hd_take = 0;
  endtask

  task automatic finish_xfer(logic [1:0] id, logic part, logic [23:0] len);
    @(negedge clk); cmp_valid = 1; cmp_id = id; cmp_partial = part; cmp_len = len;
    @(negedge clk); cmp_valid = 0; cmp_partial = 0;
  endtask

  // commit with the current staging and track the model
  task automatic commit();
    wr(12'h408, 32'd1);
    done_m[mid] = 1'b0;
    mid = id_after(mid);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset values
    rd(12'h080, rv); check("R1 mask", rv, 32'd3);
    rd(12'h084, rv); check("R1 pend", rv, 32'd0);
    rd(12'h400, rv); check("R1 ctrl", rv, 32'd0);
    rd(12'h404, rv); check("R1 nextid", rv, 32'd0);
    rd(12'h428, rv); check("R1 done", rv, 32'd0);
    rd(12'h430, rv); check("R1 status", rv, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R11 field widths
    wr(12'h418, 32'hFFFF_FFFF); rd(12'h418, rv); check("R11 xlen", rv, 32'h00FF_FFFF);
    wr(12'h40C, 32'hFF);        rd(12'h40C, rv); check("R11 flags", rv, 32'd7);

    // R9 commit while disabled is ignored
    wr(12'h408, 32'd1);
    rd(12'h408, rv); check("R9 commit ignored", rv, 32'd0);
    rd(12'h404, rv); check("R9 id unchanged", rv, 32'd0);
    rd(12'h430, rv); check("R9 idle", rv, 32'd0);

    wr(12'h400, 32'd1);
    wr(12'h080, 32'd0);

    // R2 R5 R6 R7 random single transfers
    for (int i = 0; i < 12; i++) begin
      logic [31:0] s, d, ss, ds;
      logic [23:0] xl;
      logic [15:0] yl;
      logic [2:0]  fl;
      logic [1:0]  eid;
      s = $urandom; d = $urandom; ss = $urandom; ds = $urandom;
      xl = 24'($urandom); yl = 16'($urandom); fl = 3'($urandom) & 3'b011;
      wr(12'h414, s); wr(12'h410, d); wr(12'h424, ss); wr(12'h420, ds);
      wr(12'h418, {8'd0, xl}); wr(12'h41C, {16'd0, yl}); wr(12'h40C, {29'd0, fl});
      eid = mid;
      rd(12'h404, rv); check("R2 next id", rv, {30'd0, eid});
      commit();
      rd(12'h408, rv); check("R3 accepted", rv, 32'd0);
      rd(12'h428, rv); check("R5 realloc clears", rv, done_word(done_m, 1'b0));
      rd(12'h084, rv); check("R6 sot", rv & 32'd1, 32'd1);
      wr(12'h084, 32'd3);
      check("R4 valid", {31'd0, hd_valid}, 32'd1);
      check("R2 head id", {30'd0, hd_id}, {30'd0, eid});
      check("R2 head src", hd_src, s);
      check("R2 head dst", hd_dst, d);
      check("R2 head len", {hd_xlen, hd_ylen[7:0]}, {xl, yl[7:0]});
      check("R2 head strides", hd_src_stride ^ hd_dst_stride, ss ^ ds);
      check("R2 head flags", {29'd0, hd_flags}, {29'd0, fl});
      take();
      finish_xfer(eid, 1'b0, '0);
      done_m[eid] = 1'b1;
      check("R7 irq on eot", {31'd0, irq}, 32'd1);
      rd(12'h428, rv); check("R5 done bit", rv, done_word(done_m, 1'b0));
      wr(12'h084, 32'd3);
    end

    // R3 R4 R10 queue fill, wait, pause and order
    begin
      logic [1:0] first;
      first = mid;
      for (int k = 0; k < 4; k++) commit();
      wr(12'h408, 32'd1);
      rd(12'h408, rv); check("R3 waits when full", rv, 32'd1);
      rd(12'h430, rv); check("R10 busy", rv, 32'd1);
      wr(12'h400, 32'd3);
      check("R4 paused", {31'd0, hd_valid}, 32'd0);
      wr(12'h400, 32'd1);
      check("R4 resumed", {31'd0, hd_valid}, 32'd1);
      take();
      finish_xfer(first, 1'b0, '0);
      done_m[first] = 1'b1;
      done_m[mid] = 1'b0; mid = id_after(mid);
      @(negedge clk);
      rd(12'h408, rv); check("R3 accepted later", rv, 32'd0);
      for (int k = 1; k < 5; k++) begin
        logic [1:0] eid;
        eid = 2'((int'(first) + k) % QD);
        check("R4 order", {30'd0, hd_id}, {30'd0, eid});
        take();
        finish_xfer(eid, 1'b0, '0);
        done_m[eid] = 1'b1;
      end
      rd(12'h430, rv); check("R10 idle", rv, 32'd0);
      rd(12'h428, rv); check("R5 all done", rv, done_word(done_m, 1'b0));
      wr(12'h084, 32'd3);
    end

    // R6 same-cycle: commit accepted while older transfer completes,
    // and completion event meeting a clear of its pending bit
    begin
      logic [1:0] a;
      a = mid;
      wr(12'h40C, 32'd0);
      commit();
      take();
      wr(12'h084, 32'd3);
      @(negedge clk);
      bus_wr = 1; bus_addr = 12'h408; bus_wdata = 32'd1;
      cmp_valid = 1; cmp_id = a;
      @(negedge clk);
      bus_wr = 0; cmp_valid = 0;
      done_m[a] = 1'b1; done_m[mid] = 1'b0; mid = id_after(mid);
      rd(12'h408, rv); check("R3 same-cycle accept", rv, 32'd0);
      rd(12'h404, rv); check("R2 same-cycle id", rv, {30'd0, mid});
      rd(12'h428, rv); check("R5 same-cycle done", rv, done_word(done_m, 1'b0));
      a = id_after(a);
      take();
      wr(12'h084, 32'd3);
      @(negedge clk);
      bus_wr = 1; bus_addr = 12'h084; bus_wdata = 32'd2;
      cmp_valid = 1; cmp_id = a;
      @(negedge clk);
      bus_wr = 0; cmp_valid = 0;
      done_m[a] = 1'b1;
      rd(12'h084, rv); check("R6 event beats clear", rv, 32'd2);
    end

    // R7 masking
    wr(12'h080, 32'd2);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    rd(12'h088, rv); check("R7 source masked", rv, 32'd0);
    wr(12'h080, 32'd0);
    check("R7 unmasked irq", {31'd0, irq}, 32'd1);
    rd(12'h088, rv); check("R7 source", rv, 32'd2);
    wr(12'h084, 32'd3);
    check("R7 cleared irq", {31'd0, irq}, 32'd0);

    // R8 partial records
    begin
      logic [1:0] a;
      a = mid;
      wr(12'h40C, 32'd4);
      commit();
      take();
      finish_xfer(a, 1'b1, 24'h000123);
      done_m[a] = 1'b1;
      rd(12'h428, rv); check("R8 record flag", rv, done_word(done_m, 1'b1));
      rd(12'h44C, rv); check("R8 length", rv, 32'h123);
      rd(12'h450, rv); check("R8 id", rv, {30'd0, a});
      rd(12'h428, rv); check("R8 flag clears", rv, done_word(done_m, 1'b0));
      a = mid;
      wr(12'h40C, 32'd0);
      commit();
      take();
      finish_xfer(a, 1'b1, 24'h000055);
      done_m[a] = 1'b1;
      rd(12'h428, rv); check("R8 no record without flag", rv, done_word(done_m, 1'b0));
      wr(12'h084, 32'd3);
    end

    // R9 flush discards queued and outstanding work
    begin
      logic [1:0] a;
      a = mid;
      commit(); commit();
      wr(12'h400, 32'd0);
      check("R9 head gone", {31'd0, hd_valid}, 32'd0);
      rd(12'h430, rv); check("R9 status idle", rv, 32'd0);
      finish_xfer(a, 1'b0, '0);
      rd(12'h428, rv); check("R9 completion ignored", rv, done_word(done_m, 1'b0));
      wr(12'h400, 32'd1);
      check("R9 queue empty", {31'd0, hd_valid}, 32'd0);
      rd(12'h404, rv); check("R9 id kept", rv, {30'd0, mid});
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule